// File: doc/BRIEF.md
# Infrared Transceiver Mode Programming Decoder

This block sits on the device side of an infrared transceiver. It watches two host-driven pins, the shutdown pin `sd` and the transmit data pin `txd_ir`, and works out which operating mode the host asked for. Three modes exist: low-bandwidth serial infrared (SIR), high-bandwidth (MIR/FIR), and remote-control drive from the single data input. The decoder measures how long `sd` stays high. A brief high pulse is a programming request. A pulse that stays high long enough means a real power-down.

On the falling edge of a short pulse, the level of `txd_ir` is taken as the new bandwidth choice, provided it was steady across a setup window before the edge and a hold window after it. A separate, complete `txd_ir` pulse placed late enough inside the programming pulse requests remote-control drive instead. Three pulse lengths are handled differently. A pulse too long for programming but too short for shutdown is rejected and flagged. A long pulse raises the shutdown flag while `sd` is still high and puts the mode back to SIR. All thresholds are given in nanoseconds and converted to clock cycles from the clock period parameter. Both inputs must already be synchronous to `clk`.

Top module: `mode_prog_decoder`

## Requirements
- R1: While reset is applied and right after it, `mode` is 0 (SIR), `shutdown` is 0 and `timing_err` is 0.
- R2: `mode` is encoded as 0 = SIR, 1 = MIR/FIR and 2 = remote control. The value 3 never appears. A high pulse on `sd` of at most PROG_MAX_CYC samples (625 by default) is a programming pulse. On the first low sample after such a pulse, `txd_ir` high selects 1 and `txd_ir` low selects 0. The new value appears HOLD_CYC clock edges after that low sample.
- R3: `shutdown` rises at the clock edge that samples the SHDN_CYC-th consecutive high value of `sd` (3750 by default), before `sd` falls. It stays high while `sd` stays high and clears at the first low sample.
- R4: When `shutdown` rises, `mode` becomes 0 at the same edge. A falling edge that ends a shutdown pulse never changes the mode and never sets `timing_err`.
- R5: Inside a programming pulse, a `txd_ir` pulse selects remote control (mode 2) at the falling edge of `sd` when all three of these hold: it rises at least RC_DELAY_CYC samples after the first high `sd` sample (25 by default), it stays high for at least RC_WIDTH_CYC samples (25 by default), and it falls while `sd` is still high. A pulse that is shorter or starts earlier does not select remote control.
- R6: An `sd` pulse longer than PROG_MAX_CYC samples but shorter than SHDN_CYC samples leaves `mode` unchanged and sets `timing_err`.
- R7: A programming request is a setup violation when `txd_ir` is not the same at the falling-edge sample and at the SETUP_CYC samples before it (7 by default). A setup violation sets `timing_err` and leaves `mode` unchanged.
- R8: A programming request is a hold violation when `txd_ir` changes during the HOLD_CYC samples after the falling-edge sample (7 by default). A hold violation sets `timing_err` and leaves `mode` unchanged.
- R9: `timing_err` stays set until the next rising edge of `sd`, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd | input | 1 | Shutdown / programming strobe from the host, synchronous to clk |
| txd_ir | input | 1 | Infrared transmit data from the host, synchronous to clk |
| mode | output | 2 | Current operating mode: 0 SIR, 1 MIR/FIR, 2 remote control |
| shutdown | output | 1 | High while a long sd pulse holds the part in power-down |
| timing_err | output | 1 | Sticky flag for a rejected programming attempt |

## Verification
A wrong pulse-length count shows up in one of two ways. It moves the `shutdown` rise by whole cycles. It also shifts the programming, middle-band and shutdown boundaries, and that shows as a wrong `mode` or `timing_err` one edge after `sd` falls. A wrong setup run length or a wrong hold count shows within HOLD_CYC edges of the falling edge: the mode is committed when it should be rejected, or rejected when it should be committed. Faults in the remote-control pulse tracker, such as arming too early, a wrong width count or a flag left over from an earlier pulse, only show when the next short pulse ends. They appear as mode 2 where the run expected 0 or 1, or the other way round. For that reason the remote-control pulse width and start position are each tested on both sides of their limits.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  typedef enum logic [1:0] {
    MODE_SIR  = 2'd0,
    MODE_FAST = 2'd1,
    MODE_RC   = 2'd2
  } mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } ctrl_state_e;

endpackage

// File: rtl/mpd_sd_timer.sv
module mpd_sd_timer #(
  parameter int SHDN_CYC = 3750,
  parameter int CNT_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd,
  output logic             sd_rise,
  output logic             sd_fall,
  output logic             shdn_enter,
  output logic             shutdown,
  output logic [CNT_W-1:0] hi_len
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SHDN_CYC);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SHDN_CYC - 1);

  logic             sd_q;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic             shdn_q, shdn_d;

  always_comb begin
    sd_rise    = sd & ~sd_q;
    sd_fall    = ~sd & sd_q;
    shdn_enter = sd && (hi_q == LAST);
    if (!sd)
      hi_d = '0;
    else if (hi_q == LIMIT)
      hi_d = hi_q;
    else
      hi_d = hi_q + 1'b1;
    shdn_d = sd & (shdn_q | shdn_enter);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q   <= 1'b0;
      hi_q   <= '0;
      shdn_q <= 1'b0;
    end else begin
      sd_q   <= sd;
      hi_q   <= hi_d;
      shdn_q <= shdn_d;
    end
  end

  assign hi_len   = hi_q;
  assign shutdown = shdn_q;

endmodule

// File: rtl/mpd_txd_monitor.sv
module mpd_txd_monitor #(
  parameter int SETUP_CYC    = 7,
  parameter int RC_DELAY_CYC = 25,
  parameter int RC_WIDTH_CYC = 25,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd,
  input  logic             sd_rise,
  input  logic             txd_ir,
  input  logic [CNT_W-1:0] hi_len,
  output logic             setup_ok,
  output logic             rc_seen
);

  localparam int SU_W = $clog2(SETUP_CYC + 2);
  localparam int RC_W = $clog2(RC_WIDTH_CYC + 2);
  localparam logic [SU_W-1:0]  SU_MAX = SU_W'(SETUP_CYC);
  localparam logic [RC_W-1:0]  RW_MAX = RC_W'(RC_WIDTH_CYC);
  localparam logic [CNT_W-1:0] DLY    = CNT_W'(RC_DELAY_CYC);

  logic            tx_q;
  logic [SU_W-1:0] stab_q, stab_d;
  logic            arm_q, arm_d;
  logic [RC_W-1:0] rcnt_q, rcnt_d;
  logic            seen_q, seen_d;
  logic            tx_same, tx_up, tx_dn;

  // Run length of the current txd_ir level, saturating at the setup window.
  always_comb begin
    tx_same = (txd_ir == tx_q);
    tx_up   = txd_ir & ~tx_q;
    tx_dn   = ~txd_ir & tx_q;
    if (!tx_same)
      stab_d = SU_W'(1);
    else if (stab_q == SU_MAX)
      stab_d = stab_q;
    else
      stab_d = stab_q + 1'b1;
    setup_ok = tx_same && (stab_q >= SU_MAX);
  end

  // Remote-control request: late-starting, wide, completed txd_ir pulse.
  always_comb begin
    arm_d  = arm_q;
    rcnt_d = rcnt_q;
    seen_d = seen_q;
    if (sd_rise) begin
      arm_d  = 1'b0;
      rcnt_d = '0;
      seen_d = 1'b0;
    end else if (sd) begin
      if (tx_up && (hi_len >= DLY)) begin
        arm_d  = 1'b1;
        rcnt_d = RC_W'(1);
      end else if (arm_q && txd_ir) begin
        if (rcnt_q != RW_MAX)
          rcnt_d = rcnt_q + 1'b1;
      end else if (arm_q && tx_dn) begin
        arm_d = 1'b0;
        if (rcnt_q >= RW_MAX)
          seen_d = 1'b1;
      end
    end else begin
      arm_d  = 1'b0;
      rcnt_d = '0;
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= 1'b0;
      stab_q <= '0;
      arm_q  <= 1'b0;
      rcnt_q <= '0;
      seen_q <= 1'b0;
    end else begin
      tx_q   <= txd_ir;
      stab_q <= stab_d;
      arm_q  <= arm_d;
      rcnt_q <= rcnt_d;
      seen_q <= seen_d;
    end
  end

  assign rc_seen = seen_q;

endmodule

// File: rtl/mpd_mode_ctrl.sv
module mpd_mode_ctrl
  import mpd_pkg::*;
#(
  parameter int PROG_MAX_CYC = 625,
  parameter int SHDN_CYC     = 3750,
  parameter int HOLD_CYC     = 7,
  parameter int CNT_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sd_rise,
  input  logic             sd_fall,
  input  logic             shdn_enter,
  input  logic [CNT_W-1:0] hi_len,
  input  logic             setup_ok,
  input  logic             rc_seen,
  input  logic             txd_ir,
  output logic [1:0]       mode,
  output logic             timing_err
);

  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0]  PROG_MAX  = CNT_W'(PROG_MAX_CYC);
  localparam logic [CNT_W-1:0]  SHDN_LEN  = CNT_W'(SHDN_CYC);

  ctrl_state_e       state_q, state_d;
  mode_e             mode_q, mode_d;
  logic              err_q, err_d;
  logic              cand_q, cand_d;
  logic [HOLD_W-1:0] hcnt_q, hcnt_d;

  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    err_d   = err_q;
    cand_d  = cand_q;
    hcnt_d  = hcnt_q;
    if (sd_rise)
      err_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sd_fall) begin
          if (hi_len >= SHDN_LEN) begin
            mode_d = mode_q;
          end else if (hi_len > PROG_MAX) begin
            err_d = 1'b1;
          end else if (rc_seen) begin
            mode_d = MODE_RC;
          end else if (!setup_ok) begin
            err_d = 1'b1;
          end else begin
            cand_d  = txd_ir;
            hcnt_d  = '0;
            state_d = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (txd_ir != cand_q) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (hcnt_q == HOLD_LAST) begin
          mode_d  = cand_q ? MODE_FAST : MODE_SIR;
          state_d = ST_IDLE;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (shdn_enter) begin
      mode_d  = MODE_SIR;
      state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_SIR;
      err_q   <= 1'b0;
      cand_q  <= 1'b0;
      hcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      err_q   <= err_d;
      cand_q  <= cand_d;
      hcnt_q  <= hcnt_d;
    end
  end

  assign mode       = mode_q;
  assign timing_err = err_q;

endmodule

// File: rtl/mode_prog_decoder.sv
module mode_prog_decoder #(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int PROG_MAX_NS   = 5000,
  parameter int SHDN_NS       = 30000,
  parameter int SETUP_NS      = 50,
  parameter int HOLD_NS       = 50,
  parameter int RC_DELAY_NS   = 200,
  parameter int RC_WIDTH_NS   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sd,
  input  logic       txd_ir,
  output logic [1:0] mode,
  output logic       shutdown,
  output logic       timing_err
);

  // Maximum lengths round down, minimum lengths round up.
  localparam int PROG_MAX_CYC = (PROG_MAX_NS * 1000) / CLK_PERIOD_PS;
  localparam int SHDN_CYC     = (SHDN_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SETUP_CYC    = (SETUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int HOLD_CYC     = (HOLD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RC_DELAY_CYC = (RC_DELAY_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int RC_WIDTH_CYC = (RC_WIDTH_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int CNT_W        = $clog2(SHDN_CYC + 1);

  logic             sd_rise, sd_fall, shdn_enter;
  logic [CNT_W-1:0] hi_len;
  logic             setup_ok, rc_seen;

  mpd_sd_timer #(
    .SHDN_CYC (SHDN_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd         (sd),
    .sd_rise    (sd_rise),
    .sd_fall    (sd_fall),
    .shdn_enter (shdn_enter),
    .shutdown   (shutdown),
    .hi_len     (hi_len)
  );

  mpd_txd_monitor #(
    .SETUP_CYC    (SETUP_CYC),
    .RC_DELAY_CYC (RC_DELAY_CYC),
    .RC_WIDTH_CYC (RC_WIDTH_CYC),
    .CNT_W        (CNT_W)
  ) u_txmon (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd       (sd),
    .sd_rise  (sd_rise),
    .txd_ir   (txd_ir),
    .hi_len   (hi_len),
    .setup_ok (setup_ok),
    .rc_seen  (rc_seen)
  );

  mpd_mode_ctrl #(
    .PROG_MAX_CYC (PROG_MAX_CYC),
    .SHDN_CYC     (SHDN_CYC),
    .HOLD_CYC     (HOLD_CYC),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_rise    (sd_rise),
    .sd_fall    (sd_fall),
    .shdn_enter (shdn_enter),
    .hi_len     (hi_len),
    .setup_ok   (setup_ok),
    .rc_seen    (rc_seen),
    .txd_ir     (txd_ir),
    .mode       (mode),
    .timing_err (timing_err)
  );

endmodule

// File: rtl/mpd_checker.sv
module mpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sd,
  input logic [1:0] mode,
  input logic       shutdown
);

  // R2: the unused code never appears
  a_r2_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  // R4: power-down always reports SIR
  a_r4_shutdown_sir: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> (mode == 2'd0));

  // R3: the flag can only be set by a high sd sample
  a_r3_shutdown_needs_sd: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> $past(sd));

  // R3: the flag only drops after a low sd sample
  a_r3_shutdown_clear_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shutdown) |-> !$past(sd));

  // R5: remote-control mode is entered only at a falling edge of sd
  a_r5_rc_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'd2) && ($past(mode) != 2'd2)) |-> (!$past(sd) && $past(sd, 2)));

endmodule

bind mode_prog_decoder mpd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sd       (sd),
  .mode     (mode),
  .shutdown (shutdown)
);

// File: tb/sim_mode_prog_decoder.sv
module sim_mode_prog_decoder;

  localparam int PER_PS = 8000;
  localparam int PM = 5000 * 1000 / PER_PS;
  localparam int SH = (30000 * 1000 + PER_PS - 1) / PER_PS;
  localparam int SU = (50 * 1000 + PER_PS - 1) / PER_PS;
  localparam int HO = (50 * 1000 + PER_PS - 1) / PER_PS;
  localparam int RD = (200 * 1000 + PER_PS - 1) / PER_PS;
  localparam int RP = (200 * 1000 + PER_PS - 1) / PER_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sd = 1'b0;
  logic txd_ir = 1'b0;
  logic [1:0] mode;
  logic shutdown, timing_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4ns clk = ~clk;

  mode_prog_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd         (sd),
    .txd_ir     (txd_ir),
    .mode       (mode),
    .shutdown   (shutdown),
    .timing_err (timing_err)
  );

  // Behavioural reference model
  int m_hi, m_mode, m_shdn, m_viol, m_hold, m_cand, m_rcstart, m_rcseen;
  bit m_ps, m_pt;
  bit hist[$];

  function automatic bit steady();
    if (hist.size() < SU + 1) return 1'b0;
    foreach (hist[i]) if (hist[i] != hist[0]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hi = 0; m_mode = 0; m_shdn = 0; m_viol = 0; m_hold = -1; m_cand = 0;
      m_rcstart = -1; m_rcseen = 0; m_ps = 0; m_pt = 0;
      hist.delete();
    end else begin
      bit s, t, was_hold;
      int hprev;
      s = sd; t = txd_ir; was_hold = (m_hold >= 0);
      hist.push_back(t);
      if (hist.size() > SU + 1) void'(hist.pop_front());
      if (s && !m_ps) begin m_viol = 0; m_rcseen = 0; m_rcstart = -1; m_hi = 0; end
      if (was_hold) begin
        if (t != m_cand[0]) begin m_viol = 1; m_hold = -1; end
        else begin
          m_hold++;
          if (m_hold == HO) begin m_mode = m_cand; m_hold = -1; end
        end
      end
      if (!s && m_ps) begin
        m_shdn = 0;
        if (!was_hold) begin
          if (m_hi >= SH) ;
          else if (m_hi > PM) m_viol = 1;
          else if (m_rcseen != 0) m_mode = 2;
          else if (!steady()) m_viol = 1;
          else begin m_hold = 0; m_cand = int'(t); end
        end
      end
      if (s) begin
        hprev = m_hi;
        m_hi++;
        if (t && !m_pt && hprev >= RD) m_rcstart = m_hi;
        else if (!t && m_pt && m_rcstart > 0) begin
          if (m_hi - m_rcstart >= RP) m_rcseen = 1;
          m_rcstart = -1;
        end
        if (m_hi == SH) begin m_shdn = 1; m_mode = 0; m_hold = -1; end
      end else begin
        m_hi = 0; m_rcstart = -1; m_rcseen = 0;
      end
      m_ps = s; m_pt = t;
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (int'(mode) != m_mode || int'(shutdown) != m_shdn || int'(timing_err) != m_viol) begin
        n_fail++;
        $display("FAIL R2/R3/R6 model compare at %0t: mode/shdn/err got %0d/%0d/%0d expected %0d/%0d/%0d",
                 $time, mode, shutdown, timing_err, m_mode, m_shdn, m_viol);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic program_mode(input bit fast);
    sd = 1'b1; tick(30);
    txd_ir = fast; tick(30);
    sd = 1'b0; tick(12);
    txd_ir = 1'b0; tick(5);
  endtask

  task automatic rc_pulse(input int start, input int width, input int tail);
    sd = 1'b1; tick(start);
    txd_ir = 1'b1; tick(width);
    txd_ir = 1'b0; tick(tail);
    sd = 1'b0; tick(15);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(5);
    expect_val("R1 mode in reset", int'(mode), 0);
    rst_n = 1'b1;
    tick(2);
    expect_val("R1 mode after reset", int'(mode), 0);
    expect_val("R1 shutdown after reset", int'(shutdown), 0);
    expect_val("R1 timing_err after reset", int'(timing_err), 0);

    // R2 bandwidth programming, including commit timing
    sd = 1'b1; tick(30); txd_ir = 1'b1; tick(30); sd = 1'b0;
    tick(HO);
    expect_val("R2 mode before hold window ends", int'(mode), 0);
    tick(1);
    expect_val("R2 fast mode committed", int'(mode), 1);
    tick(4); txd_ir = 1'b0; tick(5);
    program_mode(1'b0);
    expect_val("R2 SIR programmed", int'(mode), 0);

    // R5 remote control
    program_mode(1'b1);
    rc_pulse(30, 30, 20);
    expect_val("R5 remote control selected", int'(mode), 2);
    rc_pulse(30, 20, 20);
    expect_val("R5 narrow pulse gives SIR", int'(mode), 0);
    program_mode(1'b1);
    rc_pulse(10, 40, 20);
    expect_val("R5 early pulse gives SIR", int'(mode), 0);

    // R7 setup violation
    program_mode(1'b1);
    sd = 1'b1; tick(20); txd_ir = 1'b1; tick(20); txd_ir = 1'b0; tick(3); sd = 1'b0; tick(15);
    expect_val("R7 setup error flag", int'(timing_err), 1);
    expect_val("R7 mode kept", int'(mode), 1);
    tick(50);
    expect_val("R9 error flag sticky", int'(timing_err), 1);
    program_mode(1'b0);
    expect_val("R9 error cleared by new pulse", int'(timing_err), 0);
    expect_val("R9 SIR after clear", int'(mode), 0);

    // R8 hold violation
    sd = 1'b1; tick(30); txd_ir = 1'b1; tick(30); sd = 1'b0; tick(3); txd_ir = 1'b0; tick(15);
    expect_val("R8 hold error flag", int'(timing_err), 1);
    expect_val("R8 mode kept", int'(mode), 0);

    // R6 middle band
    txd_ir = 1'b1; tick(2);
    sd = 1'b1; tick(999);
    expect_val("R3 no shutdown in middle band", int'(shutdown), 0);
    tick(1); sd = 1'b0; tick(15); txd_ir = 1'b0;
    expect_val("R6 middle band error", int'(timing_err), 1);
    expect_val("R6 middle band mode kept", int'(mode), 0);

    // R2/R6 programming length boundary
    txd_ir = 1'b1; tick(2);
    sd = 1'b1; tick(PM); sd = 1'b0; tick(12); txd_ir = 1'b0; tick(5);
    expect_val("R2 longest programming pulse accepted", int'(mode), 1);
    expect_val("R2 no error at boundary", int'(timing_err), 0);
    sd = 1'b1; tick(PM + 1); sd = 1'b0; tick(15);
    expect_val("R6 one cycle over rejected", int'(mode), 1);
    expect_val("R6 error one cycle over", int'(timing_err), 1);

    // R7 setup boundary
    txd_ir = 1'b1; tick(2);
    sd = 1'b1; tick(40); txd_ir = 1'b0; tick(SU - 1); sd = 1'b0; tick(15);
    expect_val("R7 setup one short rejected", int'(mode), 1);
    expect_val("R7 setup one short error", int'(timing_err), 1);
    txd_ir = 1'b1; tick(2);
    sd = 1'b1; tick(40); txd_ir = 1'b0; tick(SU); sd = 1'b0; tick(15);
    expect_val("R7 exact setup accepted", int'(mode), 0);
    expect_val("R7 exact setup no error", int'(timing_err), 0);

    // R3/R4 shutdown
    program_mode(1'b1);
    sd = 1'b1; tick(SH - 1);
    expect_val("R3 shutdown not yet", int'(shutdown), 0);
    expect_val("R4 mode before shutdown", int'(mode), 1);
    tick(1);
    expect_val("R3 shutdown raised while sd high", int'(shutdown), 1);
    expect_val("R4 shutdown forces SIR", int'(mode), 0);
    tick(100); sd = 1'b0; tick(1);
    expect_val("R3 shutdown cleared", int'(shutdown), 0);
    tick(15);
    expect_val("R4 mode stays SIR", int'(mode), 0);
    expect_val("R4 no error after shutdown", int'(timing_err), 0);

    tick(5);
    finish_run();
  end

endmodule